// File: doc/BRIEF.md
# Prescaled CPU-Cycle Interrupt Timer

This block raises an interrupt after a programmable number of prescaled CPU bus cycles. Software writes an 8-bit start value into an up-counter. It then sets a run bit. Each bus-cycle tick advances a 9-bit prescaler, and a full prescaler period advances the counter by one. When the counter rolls over from 255 to 0, the interrupt line goes high and stays high until the next counter step, a counter load or a stop command.

The first prescaler period after a stop or a reset is half length (128 ticks). Every later period is 256 ticks. The interrupt line only changes on cycles where the counter steps, or on the register writes that clear it. A CPU handler therefore needs no separate acknowledge: it simply reloads the counter.

Two register slots exist. Bus writes are decoded by ANDing the address with `0xF00C`. A result of `0xF000` is the counter load slot, and a result of `0xF008` is the control slot.

Top module: `cpu_cycle_irq_timer`

## Requirements
- R1: A write whose address ANDed with 0xF00C equals 0xF000 loads the counter with the 8-bit data. `irq` is low from the following cycle.
- R2: A write whose masked address equals 0xF008 with data bit 0 = 0 stops counting, clears the prescaler, re-arms the short first period and drives `irq` low from the following cycle.
- R3: A write whose masked address equals 0xF008 with data bit 0 = 1 starts counting and leaves the prescaler value and the first-period flag untouched. A second such write while running does not restart the period.
- R4: After reset or a stop, the first counter step of a run occurs on the 128th tick.
- R5: Every counter step after the first of a run occurs 256 ticks after the previous one.
- R6: A counter step that carries the counter from 255 to 0 drives `irq` high on the next cycle.
- R7: A counter step from any other value drives `irq` low on the next cycle.
- R8: On cycles with no counter step, no counter load and no stop command, `irq` keeps its value.
- R9: Reset clears the counter to 0, stops counting, clears the prescaler, arms the short first period and drives `irq` low.
- R10: When a counter load and a counter step fall in the same cycle, the loaded value wins and `irq` goes low.
- R11: While stopped, ticks change neither the prescaler nor the counter. Writes whose masked address matches neither slot (for example 0xF004 or 0xE008) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| m2_tick | input | 1 | One-cycle pulse per CPU bus cycle |
| wr_en | input | 1 | Bus write strobe, one cycle |
| wr_addr | input | 16 | Bus write address |
| wr_data | input | 8 | Bus write data |
| irq | output | 1 | Active-high level interrupt request |

## Verification
Every register write and every tick is taken at the clock edge where it is presented, so its result is visible at the outputs one cycle later. A step caused by the Nth tick shows on `irq` right after that Nth edge. The bench drives inputs and samples `irq` on the falling edge, halfway between updates. Its behavioural model advances on the same rising edge as the design, so the two are compared on every cycle with no skew. The directed runs count ticks until `irq` rises and compare the count against the exact sum of periods: 128, 512, 56, 61440 and 65408 ticks. A one-tick timing error or a lost load therefore shows up as a wrong count.

// File: rtl/cit_pkg.sv
package cit_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned PRE_W  = 9;

    localparam logic [ADDR_W-1:0] SEL_MASK = 16'hF00C;
    localparam logic [ADDR_W-1:0] LOAD_SEL = 16'hF000;
    localparam logic [ADDR_W-1:0] CTRL_SEL = 16'hF008;

    localparam int unsigned SHORT_PERIOD = 128;
    localparam int unsigned LONG_PERIOD  = 256;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_LOAD,
        WR_RUN,
        WR_HALT
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e            kind;
        logic [DATA_W-1:0]   value;
    } wr_cmd_t;

    typedef struct packed {
        logic                run;
        logic                first;
        logic [PRE_W-1:0]    pre;
    } pre_state_t;

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic                irq;
    } cnt_state_t;

    function automatic wr_kind_e classify(input logic valid,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic bit0);
        wr_kind_e k;
        k = WR_IDLE;
        if (valid) begin
            if ((addr & SEL_MASK) == LOAD_SEL) begin
                k = WR_LOAD;
            end else if ((addr & SEL_MASK) == CTRL_SEL) begin
                k = bit0 ? WR_RUN : WR_HALT;
            end
        end
        return k;
    endfunction

endpackage

// File: rtl/cit_wr_decode.sv
module cit_wr_decode
    import cit_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd
);

    always_comb begin
        cmd.kind  = classify(wr_en, wr_addr, wr_data[0]);
        cmd.value = wr_data;
    end

endmodule

// File: rtl/cit_prescale.sv
module cit_prescale
    import cit_pkg::*;
#(
    parameter int unsigned SHORT = SHORT_PERIOD,
    parameter int unsigned LONG  = LONG_PERIOD
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       go,
    input  logic       halt,
    output pre_state_t st,
    output logic       step
);

    localparam logic [PRE_W-1:0] SHORT_V = PRE_W'(SHORT);
    localparam logic [PRE_W-1:0] LONG_V  = PRE_W'(LONG);

    pre_state_t       st_d;
    logic [PRE_W-1:0] period;
    logic [PRE_W-1:0] inc;

    always_comb begin
        period = st.first ? SHORT_V : LONG_V;
        inc    = st.pre + 1'b1;
        step   = st.run && tick && !halt && (inc == period);
        st_d   = st;
        if (halt) begin
            st_d.run   = 1'b0;
            st_d.first = 1'b1;
            st_d.pre   = '0;
        end else begin
            if (st.run && tick) begin
                st_d.pre = step ? (inc - period) : inc;
                if (step) begin
                    st_d.first = 1'b0;
                end
            end
            if (go) begin
                st_d.run = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{run: 1'b0, first: 1'b1, pre: '0};
        end else begin
            st <= st_d;
        end
    end

endmodule

// File: rtl/cit_count_irq.sv
module cit_count_irq
    import cit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             halt,
    input  logic             step,
    output cnt_state_t       st
);

    cnt_state_t     st_d;
    logic [CNT_W:0] sum;

    always_comb begin
        sum  = {1'b0, st.cnt} + 1'b1;
        st_d = st;
        if (load) begin
            st_d.cnt = load_val;
            st_d.irq = 1'b0;
        end else if (halt) begin
            st_d.irq = 1'b0;
        end else if (step) begin
            st_d.cnt = sum[CNT_W-1:0];
            st_d.irq = sum[CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{cnt: '0, irq: 1'b0};
        end else begin
            st <= st_d;
        end
    end

endmodule

// File: rtl/cpu_cycle_irq_timer.sv
module cpu_cycle_irq_timer
    import cit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        m2_tick,
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    output logic        irq
);

    wr_cmd_t          cmd;
    pre_state_t       pst;
    cnt_state_t       cst;
    logic             cmd_load;
    logic             cmd_run;
    logic             cmd_halt;
    logic             step_pulse;
    logic             run_q;
    logic             first_q;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    cit_wr_decode u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    assign cmd_load = (cmd.kind == WR_LOAD);
    assign cmd_run  = (cmd.kind == WR_RUN);
    assign cmd_halt = (cmd.kind == WR_HALT);

    cit_prescale #(
        .SHORT (SHORT_PERIOD),
        .LONG  (LONG_PERIOD)
    ) u_prescale (
        .clk  (clk),
        .rst  (rst),
        .tick (m2_tick),
        .go   (cmd_run),
        .halt (cmd_halt),
        .st   (pst),
        .step (step_pulse)
    );

    cit_count_irq u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd_load),
        .load_val (cmd.value[CNT_W-1:0]),
        .halt     (cmd_halt),
        .step     (step_pulse),
        .st       (cst)
    );

    assign run_q   = pst.run;
    assign first_q = pst.first;
    assign pre_q   = pst.pre;
    assign cnt_q   = cst.cnt;
    assign irq     = cst.irq;

endmodule

// File: rtl/cit_checker.sv
module cit_checker
    import cit_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             m2_tick,
    input logic [7:0]       wr_data,
    input logic             cmd_load,
    input logic             cmd_run,
    input logic             cmd_halt,
    input logic             step_pulse,
    input logic             run_q,
    input logic             first_q,
    input logic [PRE_W-1:0] pre_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             irq
);

    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R9: state right after a reset cycle
    always_ff @(posedge clk) begin
        if (rst_seen === 1'b1) begin
            p_reset_state_r9: assert (cnt_q == '0 && !irq && !run_q && first_q && pre_q == '0)
                else $error("reset state wrong");
        end
    end

    p_load_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_load |=> (!irq && cnt_q == $past(wr_data)));

    p_halt_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_halt |=> (!irq && !run_q && first_q && pre_q == '0));

    p_run_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_run && !m2_tick) |=> (run_q && $stable(pre_q) && $stable(first_q)));

    p_short_bound_r4: assert property (@(posedge clk) disable iff (rst)
        first_q |-> (pre_q < PRE_W'(SHORT_PERIOD)));

    p_long_bound_r5: assert property (@(posedge clk) disable iff (rst)
        !first_q |-> (pre_q < PRE_W'(LONG_PERIOD)));

    p_wrap_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (step_pulse && !cmd_load && cnt_q == '1) |=> irq);

    p_step_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (step_pulse && !cmd_load && cnt_q != '1) |=> !irq);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!step_pulse && !cmd_load && !cmd_halt) |=> $stable(irq));

    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_load && step_pulse) |=> (cnt_q == $past(wr_data) && !irq));

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cmd_halt && !cmd_load) |=> ($stable(pre_q) && $stable(cnt_q)));

endmodule

bind cpu_cycle_irq_timer cit_checker u_cit_checker (
    .clk        (clk),
    .rst        (rst),
    .m2_tick    (m2_tick),
    .wr_data    (wr_data),
    .cmd_load   (cmd_load),
    .cmd_run    (cmd_run),
    .cmd_halt   (cmd_halt),
    .step_pulse (step_pulse),
    .run_q      (run_q),
    .first_q    (first_q),
    .pre_q      (pre_q),
    .cnt_q      (cnt_q),
    .irq        (irq)
);

// File: tb/cpu_cycle_irq_timer_bench.sv
`timescale 1ns/1ps
module cpu_cycle_irq_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m2_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int  m_cnt = 0;
    int  m_pre = 0;
    bit  m_run = 0;
    bit  m_first = 1;
    bit  m_irq = 0;

    always #4 clk = ~clk;

    cpu_cycle_irq_timer u_cpu_cycle_irq_timer (
        .clk     (clk),
        .rst     (rst),
        .m2_tick (m2_tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq     (irq)
    );

    // behavioural model, advances on the same edge as the design
    always @(posedge clk) begin
        bit is_load, is_ctl, stepped;
        int per;
        if (rst) begin
            m_cnt = 0; m_pre = 0; m_run = 0; m_first = 1; m_irq = 0;
        end else begin
            is_load = wr_en && ((wr_addr & 16'hF00C) == 16'hF000);
            is_ctl  = wr_en && ((wr_addr & 16'hF00C) == 16'hF008);
            stepped = 0;
            if (is_ctl && !wr_data[0]) begin
                m_run = 0; m_pre = 0; m_first = 1; m_irq = 0;
            end else begin
                if (m_run && m2_tick) begin
                    per = m_first ? 128 : 256;
                    m_pre = m_pre + 1;
                    if (m_pre >= per) begin
                        m_pre = m_pre - per;
                        m_first = 0;
                        stepped = 1;
                    end
                end
                if (is_ctl) m_run = 1;
            end
            if (is_load) begin
                m_cnt = wr_data; m_irq = 0;
            end else if (stepped) begin
                if (m_cnt == 255) begin m_cnt = 0; m_irq = 1; end
                else begin m_cnt = m_cnt + 1; m_irq = 0; end
            end
        end
    end

    // per-cycle comparison against the model (R6, R7, R8)
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_chk++;
            if (irq !== m_irq) begin
                n_fail++;
                $display("FAIL R8 model compare at %0t: actual irq=%0b expected %0b", $time, irq, m_irq);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic tk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; m2_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; m2_tick = 1'b0;
    endtask

    task automatic idle(input int n, input logic tk);
        m2_tick = tk;
        repeat (n) @(negedge clk);
        m2_tick = 1'b0;
    endtask

    task automatic run_until_irq(output int n);
        n = 0;
        m2_tick = 1'b1;
        while (n < 70000) begin
            @(negedge clk);
            n++;
            if (irq) break;
        end
        m2_tick = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(irq == 1'b0, "R9 reset irq", irq, 0);

        // R4 + R6: short first period, wrap from 0xFF
        wr(16'hF000, 8'hFF, 1'b0);
        wr(16'hF008, 8'h01, 1'b0);
        run_until_irq(n);
        chk(n == 128, "R4 first period ticks", n, 128);

        // R8: hold while no step
        idle(50, 1'b0);
        chk(irq == 1'b1, "R8 irq holds", irq, 1);

        // R1: load clears irq; R5: full periods
        wr(16'hF000, 8'hFE, 1'b0);
        chk(irq == 1'b0, "R1 load clears irq", irq, 0);
        run_until_irq(n);
        chk(n == 512, "R5 two long periods", n, 512);

        // R2: halt mid period; R11: ticks ignored while stopped
        idle(100, 1'b1);
        wr(16'hF00B, 8'h00, 1'b0);
        chk(irq == 1'b0, "R2 halt clears irq", irq, 0);
        idle(300, 1'b1);
        chk(irq == 1'b0, "R11 stopped stays low", irq, 0);
        wr(16'hF0F3, 8'hFF, 1'b0);
        wr(16'hF00B, 8'h01, 1'b0);
        run_until_irq(n);
        chk(n == 128, "R2 short period re-armed", n, 128);

        // R3: second run write keeps prescaler; R11: non-matching writes ignored
        idle(200, 1'b1);
        wr(16'hF008, 8'h01, 1'b0);
        wr(16'hF004, 8'h00, 1'b0);
        wr(16'hE008, 8'h00, 1'b0);
        wr(16'hF000, 8'hFF, 1'b0);
        run_until_irq(n);
        chk(n == 56, "R3 R11 prescaler kept", n, 56);

        // R7: non-wrap step clears irq
        idle(255, 1'b1);
        chk(irq == 1'b1, "R7 before step", irq, 1);
        idle(1, 1'b1);
        chk(irq == 1'b0, "R7 step clears irq", irq, 0);

        // R10: load and step in the same cycle
        idle(255, 1'b1);
        wr(16'hF000, 8'h10, 1'b1);
        chk(irq == 1'b0, "R10 load wins irq", irq, 0);
        run_until_irq(n);
        chk(n == 61440, "R10 loaded value kept", n, 61440);

        // mixed traffic checked by the model
        for (int i = 0; i < 4000; i++) begin
            int pick;
            pick = $urandom_range(0, 15);
            wr_en = (pick < 3);
            case (pick)
                0: wr_addr = 16'hF000 | 16'($urandom_range(0, 3)) | 16'h0FF0;
                1: wr_addr = 16'hF008 | 16'($urandom_range(0, 3));
                default: wr_addr = 16'($urandom_range(0, 65535));
            endcase
            wr_data = 8'($urandom_range(200, 255));
            if (pick == 1 && $urandom_range(0, 7) != 0) wr_data[0] = 1'b1;
            m2_tick = ($urandom_range(0, 3) != 0);
            @(negedge clk);
        end
        wr_en = 1'b0; m2_tick = 1'b0;

        // R9: reset mid-run clears the counter
        rst = 1'b1;
        idle(2, 1'b1);
        rst = 1'b0;
        chk(irq == 1'b0, "R9 irq after reset", irq, 0);
        wr(16'hF008, 8'h01, 1'b0);
        run_until_irq(n);
        chk(n == 65408, "R9 counter cleared", n, 65408);

        finish_up();
    end

endmodule